// File: doc/BRIEF.md
# Serial Ferroelectric Memory Write/Readback Tester

This block drives a serial ferroelectric memory over SPI (mode 0, most significant bit first). On a write request it enables writing on the memory, then writes a fixed run of computed pattern bytes to a fixed start address. On a read request it reads the same number of bytes back from that address into an internal byte store. The store is exposed on a flat output bus so that surrounding logic can compare or display it.

The only clock in the SPI logic is divided down from the system clock. With the default divide ratio, a 50 MHz system clock gives 5 MHz, well inside the memory's 20 MHz limit. The control state machine and its two per-state counters (a bit counter and a byte counter) advance on the falling edge of that clock, so MOSI is settled when the memory samples it on the rising edge. The returned MISO bits are stored on the rising edge, half a period after the memory has driven them. The read request behaves like a switch: after a read the machine parks with the select line high until the request is released.

Top module: `fram_wr_rd_tester`

## Requirements
- R1: SCK has a period of DIV system clocks, with a high time of DIV/2 system clocks. SCK is low whenever ss_n is high.
- R2: After reset, and after a reset applied in the middle of a frame, ss_n is high and both sck and mosi are low.
- R3: When wr_req is high in idle, the first frame holds ss_n low for 8 SCK cycles and carries opcode 0x06. ss_n then stays high for at least one SCK period before the next frame starts.
- R4: The second write frame carries opcode 0x02, then the AW-bit address BASE_ADDR, then NB data bytes. Data byte k has (2k mod 16) in its upper nibble and (2k+1 mod 16) in its lower nibble. With the default NB of 8 this is 0x0123456789ABCDEF. No further frame follows while wr_req stays low.
- R5: MOSI changes only on the falling edge of SCK and is stable while SCK is high.
- R6: When rd_sw is high in idle, a single frame carries opcode 0x03, then BASE_ADDR, then 8*NB clocks with MOSI held low.
- R7: In the data phase of a read, MISO is sampled on each rising SCK edge. The first bit received is bit 7 of byte 0, and byte k appears at rd_bytes[8k+7:8k].
- R8: After a read frame, ss_n stays high and no new frame starts while rd_sw remains high. Releasing rd_sw returns the machine to idle.
- R9: If wr_req and rd_sw are both high at an idle decision, the write (opcode 0x06 frame first) is performed before the read.
- R10: A frame holds ss_n low for exactly 8 SCK rises (write enable) or 8+AW+8*NB rises (write and read).
- R11: MISO has no effect on rd_bytes outside the data phase of a read frame, including during write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Starts the write sequence when seen high in idle |
| rd_sw | input | 1 | Starts a read; holds the machine parked afterwards while high |
| miso | input | 1 | Serial data from the memory |
| ss_n | output | 1 | Active-low chip select |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the memory |
| rd_bytes | output | 8*NB | Captured bytes, byte k at bits 8k+7:8k |

## Verification
Both requests can be seen high at the same idle decision on a falling SPI edge. The bench provokes this by raising wr_req and rd_sw in the same system cycle. It judges the outcome from the frames recorded by its slave model: the first frame must be the 0x06 write-enable, and the write frame must come next. The read frame must follow only once the write has finished, and it must capture the pattern served on MISO. A second overlap is MISO activity during write frames and during opcode and address bits. The bench drives MISO high throughout those spans and checks that the previously captured bytes survive unchanged.

// File: rtl/fram_tst_pkg.sv
package fram_tst_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_WOP, S_WADR, S_WDAT, S_WEND,
    S_ROP, S_RADR, S_RDAT, S_RWAIT
  } st_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  // byte k: upper nibble 2k, lower nibble 2k+1 (both mod 16)
  function automatic logic [7:0] pattern_byte(input int k);
    pattern_byte = {4'((2 * k) % 16), 4'((2 * k + 1) % 16)};
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic spi_clk,
  output logic fsm_rst
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  // reset is held pending until the divided clock has fallen once with it set
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      spi_clk <= 1'b1;
      fsm_rst <= 1'b1;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt     <= '0;
      spi_clk <= ~spi_clk;
      if (!spi_clk) fsm_rst <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  half_period_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != CW'(HALF - 1)) |=> $stable(spi_clk));

endmodule

// File: rtl/fram_bit_timers.sv
module fram_bit_timers #(
  parameter int JW = 3
) (
  input  logic          spi_clk,
  input  logic          rst,
  input  logic [2:0]    imax,
  input  logic [JW-1:0] jmax,
  output logic [2:0]    i,
  output logic [JW-1:0] j,
  output logic          last
);
  assign last = (i == imax) && (j == jmax);

  always_ff @(negedge spi_clk) begin
    if (rst || last) begin
      i <= '0;
      j <= '0;
    end else if (i == imax) begin
      i <= '0;
      j <= j + 1'b1;
    end else begin
      i <= i + 1'b1;
    end
  end

  // R10
  bit_range_chk: assert property (@(negedge spi_clk) disable iff (rst)
    (i <= imax) && (j <= jmax));

endmodule

// File: rtl/fram_rx_store.sv
module fram_rx_store #(
  parameter int NB = 8,
  parameter int JW = 3
) (
  input  logic            spi_clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [2:0]      i,
  input  logic [JW-1:0]   j,
  input  logic            miso,
  output logic [8*NB-1:0] rd_bytes
);
  logic [7:0] mem [NB];
  logic [6:0] sh;

  always_ff @(posedge spi_clk) begin
    if (cap_en) begin
      sh <= {sh[5:0], miso};
      if (i == 3'd7) mem[j] <= {sh, miso};
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign rd_bytes[8*g +: 8] = mem[g];
  end

  // R11
  no_stray_cap_chk: assert property (@(posedge spi_clk) disable iff (rst)
    !cap_en |=> $stable(rd_bytes));

endmodule

// File: rtl/fram_wr_rd_tester.sv
module fram_wr_rd_tester #(
  parameter int              DIV       = 10,
  parameter int              AW        = 16,
  parameter int              NB        = 8,
  parameter logic [AW-1:0]   BASE_ADDR = 16'h0040
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic            rd_sw,
  input  logic            miso,
  output logic            ss_n,
  output logic            sck,
  output logic            mosi,
  output logic [8*NB-1:0] rd_bytes
);
  import fram_tst_pkg::*;

  localparam int AB = AW / 8;
  localparam int JN = (NB > AB) ? NB : AB;
  localparam int JW = (JN > 1) ? $clog2(JN) : 1;

  logic          spi_clk, fsm_rst;
  st_t           st, nxt;
  logic [2:0]    i, imax;
  logic [JW-1:0] j, jmax;
  logic          last, sck_en;
  logic [AW-1:0] adr_sh;
  logic [7:0]    abyte, pbyte;

  spi_clk_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .fsm_rst(fsm_rst)
  );

  fram_bit_timers #(.JW(JW)) u_tmr (
    .spi_clk(spi_clk), .rst(fsm_rst), .imax(imax), .jmax(jmax),
    .i(i), .j(j), .last(last)
  );

  fram_rx_store #(.NB(NB), .JW(JW)) u_rx (
    .spi_clk(spi_clk), .rst(fsm_rst), .cap_en(st == S_RDAT),
    .i(i), .j(j), .miso(miso), .rd_bytes(rd_bytes)
  );

  assign adr_sh = BASE_ADDR << (8 * int'(j));
  assign abyte  = adr_sh[AW-1 -: 8];
  assign pbyte  = pattern_byte(int'(j));

  always_ff @(negedge spi_clk) begin
    if (fsm_rst) st <= S_IDLE;
    else         st <= nxt;
  end

  always_comb begin
    nxt    = st;
    ss_n   = 1'b1;
    sck_en = 1'b0;
    mosi   = 1'b0;
    imax   = 3'd0;
    jmax   = '0;
    case (st)
      S_IDLE: begin
        if (wr_req)     nxt = S_WREN;
        else if (rd_sw) nxt = S_ROP;
      end
      S_WREN: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; mosi = OP_WREN[~i];
        if (last) nxt = S_GAP;
      end
      S_GAP:  if (last) nxt = S_WOP;
      S_WOP: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; mosi = OP_WRITE[~i];
        if (last) nxt = S_WADR;
      end
      S_WADR: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; jmax = JW'(AB - 1);
        mosi = abyte[~i];
        if (last) nxt = S_WDAT;
      end
      S_WDAT: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; jmax = JW'(NB - 1);
        mosi = pbyte[~i];
        if (last) nxt = S_WEND;
      end
      S_WEND: if (last) nxt = S_IDLE;
      S_ROP: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; mosi = OP_READ[~i];
        if (last) nxt = S_RADR;
      end
      S_RADR: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; jmax = JW'(AB - 1);
        mosi = abyte[~i];
        if (last) nxt = S_RDAT;
      end
      S_RDAT: begin
        ss_n = 1'b0; sck_en = 1'b1; imax = 3'd7; jmax = JW'(NB - 1);
        if (last) nxt = S_RWAIT;
      end
      S_RWAIT: if (!rd_sw) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign sck = sck_en & spi_clk;

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> !sck);

  // R9
  write_first_chk: assert property (@(negedge spi_clk) disable iff (fsm_rst)
    (st == S_IDLE && wr_req) |=> (st == S_WREN));

  // R8
  wait_hold_chk: assert property (@(negedge spi_clk) disable iff (fsm_rst)
    (st == S_RWAIT && rd_sw) |=> (st == S_RWAIT));

endmodule

// File: tb/fram_wr_rd_tester_test.sv
module fram_wr_rd_tester_test;

  localparam int CLK_PERIOD = 20;
  localparam int DIV  = 10;
  localparam int AW   = 16;
  localparam int NB   = 8;
  localparam logic [15:0] ADDR = 16'h0040;
  localparam int SPI_T = CLK_PERIOD * DIV;
  localparam int FLEN  = 8 + AW + 8 * NB;
  localparam logic [63:0] WPAT = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] RD_VEC [0:3] = '{
    64'h0000_0000_0000_0000, 64'hA5A5_0F0F_3C3C_FF00,
    64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001 };

  logic clk = 1'b0, rst = 1'b1, wr_req = 1'b0, rd_sw = 1'b0, miso = 1'b1;
  logic ss_n, sck, mosi;
  logic [8*NB-1:0] rd_bytes;

  fram_wr_rd_tester #(.DIV(DIV), .AW(AW), .NB(NB), .BASE_ADDR(ADDR)) uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_sw(rd_sw), .miso(miso),
    .ss_n(ss_n), .sck(sck), .mosi(mosi), .rd_bytes(rd_bytes)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  int cur_n = 0, frames_done = 0, mosi_viol = 0;
  logic [127:0] cur_v = '0;
  int flen [32];
  logic [127:0] fval [32];
  time t_up = 0, last_gap = 0;
  logic rd_active = 1'b0;
  logic [63:0] exp_bytes = '0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  always @(negedge ss_n) begin
    cur_n = 0;
    cur_v = '0;
    if (frames_done > 0) last_gap = $time - t_up;
  end
  always @(posedge sck) if (!ss_n) begin
    cur_v = {cur_v[126:0], mosi};
    cur_n++;
  end
  always @(posedge ss_n) if (cur_n > 0) begin
    flen[frames_done % 32] = cur_n;
    fval[frames_done % 32] = cur_v;
    frames_done++;
    t_up  = $time;
    cur_n = 0;
  end
  always @(negedge sck or posedge ss_n) begin
    int d;
    d = cur_n - (8 + AW);
    if (rd_active && !ss_n && d >= 0 && d < 8 * NB)
      miso = exp_bytes[8 * (d / 8) + 7 - (d % 8)];
    else
      miso = 1'b1;
  end
  always @(posedge sck) begin
    logic m;
    m = mosi;
    #(SPI_T / 2 - 5);
    if (mosi !== m) mosi_viol++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_run(input logic [63:0] pat);
    int n0;
    rd_active = 1'b1;
    exp_bytes = pat;
    n0 = frames_done;
    rd_sw = 1'b1;
    wait (frames_done == n0 + 1);
    wait_clk(4 * DIV);
    chk(ss_n == 1'b1 && frames_done == n0 + 1, "R8 parked while rd_sw high",
        128'(frames_done), 128'(n0 + 1));
    chk(flen[n0] == FLEN, "R10 read frame length", 128'(flen[n0]), 128'(FLEN));
    chk(fval[n0][FLEN-1:0] == {8'h03, ADDR, 64'h0}, "R6 read frame bits",
        fval[n0], 128'({8'h03, ADDR, 64'h0}));
    chk(rd_bytes == pat, "R7 captured bytes", 128'(rd_bytes), 128'(pat));
    rd_sw = 1'b0;
    wait_clk(3 * DIV);
    rd_active = 1'b0;
  endtask

  task automatic write_run(input bit measure);
    int n0;
    time t0, t1, t2;
    n0 = frames_done;
    wr_req = 1'b1;
    @(posedge sck) t0 = $time;
    @(negedge sck) t1 = $time;
    @(posedge sck) t2 = $time;
    wr_req = 1'b0;
    if (measure) begin
      chk(t2 - t0 == SPI_T, "R1 SCK period", 128'(t2 - t0), 128'(SPI_T));
      chk(t1 - t0 == SPI_T / 2, "R1 SCK high time", 128'(t1 - t0), 128'(SPI_T / 2));
    end
    wait (frames_done == n0 + 2);
    wait_clk(2);
    chk(flen[n0] == 8, "R10 enable frame length", 128'(flen[n0]), 128'd8);
    chk(fval[n0][7:0] == 8'h06, "R3 enable opcode", fval[n0], 128'h06);
    chk(last_gap >= SPI_T, "R3 select gap", 128'(last_gap), 128'(SPI_T));
    chk(flen[n0+1] == FLEN, "R10 write frame length", 128'(flen[n0+1]), 128'(FLEN));
    chk(fval[n0+1][FLEN-1:0] == {8'h02, ADDR, WPAT}, "R4 write frame bits",
        fval[n0+1], 128'({8'h02, ADDR, WPAT}));
    wait_clk(4 * DIV);
    chk(frames_done == n0 + 2, "R4 no repeat frame", 128'(frames_done), 128'(n0 + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3 * DIV);
    // R2 reset state
    chk(ss_n == 1'b1, "R2 ss_n after reset", 128'(ss_n), 128'd1);
    chk(sck == 1'b0, "R2 sck after reset", 128'(sck), 128'd0);
    chk(mosi == 1'b0, "R2 mosi after reset", 128'(mosi), 128'd0);

    write_run(1'b1);

    for (int v = 0; v < 4; v++) read_run(RD_VEC[v]);

    // R11: write frames with MISO high must not touch the store
    write_run(1'b0);
    chk(rd_bytes == RD_VEC[3], "R11 store kept over write", 128'(rd_bytes), 128'(RD_VEC[3]));

    // R9: both requests together
    rd_active = 1'b1;
    exp_bytes = 64'hDEAD_BEEF_5555_AAAA;
    n0 = frames_done;
    wr_req = 1'b1;
    rd_sw  = 1'b1;
    wait (frames_done == n0 + 1);
    wr_req = 1'b0;
    chk(fval[n0][7:0] == 8'h06 && flen[n0] == 8, "R9 write enable first",
        fval[n0], 128'h06);
    wait (frames_done == n0 + 3);
    wait_clk(2);
    chk(fval[n0+1][FLEN-1:FLEN-8] == 8'h02, "R9 write second",
        128'(fval[n0+1][FLEN-1:FLEN-8]), 128'h02);
    chk(fval[n0+2][FLEN-1:FLEN-8] == 8'h03, "R9 read after write",
        128'(fval[n0+2][FLEN-1:FLEN-8]), 128'h03);
    chk(rd_bytes == 64'hDEAD_BEEF_5555_AAAA, "R7 captured after overlap",
        128'(rd_bytes), 128'h00DEADBEEF5555AAAA);
    rd_sw = 1'b0;
    wait_clk(3 * DIV);
    rd_active = 1'b0;

    // R2: reset in the middle of a frame
    wr_req = 1'b1;
    repeat (3) @(posedge sck);
    wr_req = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(3 * DIV);
    chk(ss_n == 1'b1, "R2 ss_n after mid-frame reset", 128'(ss_n), 128'd1);
    chk(sck == 1'b0, "R2 sck after mid-frame reset", 128'(sck), 128'd0);
    chk(mosi == 1'b0, "R2 mosi after mid-frame reset", 128'(mosi), 128'd0);

    chk(mosi_viol == 0, "R5 mosi stable while sck high", 128'(mosi_viol), 128'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule